// File: doc/BRIEF.md
# DDR2 Precharge Power-Down Sequencer

This block sits beside a DDR2 memory controller and decides when the memory clock-enable line may drop for precharge power-down and when it may rise again. Software holds a level control input high to request power-down. The request is not acted on while the controller is executing an access or still has requests waiting in its queue. Those requests are serviced first, and clock enable falls on the cycle after the controller reports that it is idle.

While the memory is powered down, the block reports this on a status output. It also holds its access-ready output low, and that output gates both the refresh engine and the command path. Only software dropping the control input ends power-down, and even then clock enable stays low for a programmable minimum number of cycles. After clock enable rises, the block holds access-ready low for an exit window. That window is the larger of the power-down exit delay and one of two active-exit delays, chosen by an input.

No refresh can be issued while the memory is powered down. For this reason a residence counter compares the time spent in power-down against a programmable limit, which is normally about nine refresh intervals. It raises a sticky overrun flag when the limit is exceeded.

Top module: `cke_pd_seq`

## Requirements
- R1: After reset, `cke` is 1, `pdStat` is 0, `accessReady` is 1 and `overrun` is 0.
- R2: When `pdReq` is 1 and both `accBusy` and `queuePend` are 0 while `accessReady` is 1, then after the next clock edge `cke` is 0, `pdStat` is 1 and `accessReady` is 0.
- R3: While `accBusy` or `queuePend` is 1, entry is deferred and `cke` stays 1. Entry happens one edge after both inputs are 0, provided `pdReq` is still 1.
- R4: With `pdReq` at 0 and the block active, `cke` and `accessReady` stay 1 whatever `accBusy` and `queuePend` do.
- R5: While powered down with `pdReq` at 1, `cke` stays 0 and `accessReady` stays 0, regardless of `accBusy` and `queuePend`.
- R6: `pdStat` falls on the same cycle that `cke` rises, and is 1 exactly while `cke` is 0.
- R7: If `pdReq` is cleared early, `cke` stays low for exactly max(`tCke`,1) cycles.
- R8: If `pdReq` is cleared after the minimum low time has elapsed, `cke` rises one edge after the clear is sampled.
- R9: `accessReady` rises exactly max(W,1) cycles after `cke` rises. W is the larger of `tXp` and either `tXards` (when `slowExit` is 1) or `tXard` (when `slowExit` is 0).
- R10: `accessReady` is 0 whenever `cke` is 0, and is 0 on the cycle `cke` rises.
- R11: `overrun` becomes 1 if `cke` stays low for more than `resLimit` cycles; it is visible `resLimit`+1 cycles after `cke` falls and remains 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| pdReq | input | 1 | Software power-down request level (1 = request) |
| accBusy | input | 1 | Controller is executing an access |
| queuePend | input | 1 | Requests remain in the access queue |
| slowExit | input | 1 | Selects `tXards` (1) or `tXard` (0) for the exit window |
| tCke | input | TW | Minimum clock-enable low time in cycles |
| tXp | input | TW | Power-down exit delay in cycles |
| tXard | input | TW | Fast active exit delay in cycles |
| tXards | input | TW | Slow active exit delay in cycles |
| resLimit | input | RW | Residence limit in cycles before overrun |
| cke | output | 1 | Memory clock enable |
| pdStat | output | 1 | Power-down status |
| accessReady | output | 1 | Access and refresh path allowed |
| overrun | output | 1 | Sticky flag for a residence limit overrun |

## Verification
Entry is due one edge after an idle request is sampled. Exit after a late clear is due one edge later. An early clear yields a rise exactly max(`tCke`,1) cycles after `cke` fell, access-ready follows max(W,1) cycles after `cke` rises, and overrun shows `resLimit`+1 cycles after entry. The bench drives and samples only on falling edges and counts whole cycles between them. Each delay check therefore samples one cycle before the due cycle, expecting the old value, and again on the due cycle, expecting the new one. This pins the result to that exact cycle.

// File: rtl/cke_pd_pkg.sv
package cke_pd_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_PD     = 2'd1,
    ST_EXIT   = 2'd2
  } pdState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic enter;
    logic leave;
    logic inPd;
    logic inExit;
  } pdStrobe_t;

  // timing flags from datapath to control
  typedef struct packed {
    logic lowDone;
    logic exitDone;
  } pdFlag_t;
endpackage

// File: rtl/cke_pd_ctrl.sv
module cke_pd_ctrl
  import cke_pd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      pdReq,
  input  logic      accBusy,
  input  logic      queuePend,
  input  pdFlag_t   flags,
  output pdStrobe_t strb,
  output logic      cke,
  output logic      pdStat,
  output logic      accessReady
);
  pdState_e state, nxt;

  always_comb begin
    nxt  = state;
    strb = '0;
    case (state)
      ST_ACTIVE: begin
        if (pdReq && !accBusy && !queuePend) begin
          nxt        = ST_PD;
          strb.enter = 1'b1;
        end
      end
      ST_PD: begin
        strb.inPd = 1'b1;
        if (!pdReq && flags.lowDone) begin
          nxt        = ST_EXIT;
          strb.leave = 1'b1;
        end
      end
      ST_EXIT: begin
        strb.inExit = 1'b1;
        if (flags.exitDone) nxt = ST_ACTIVE;
      end
      default: nxt = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_ACTIVE;
      cke         <= 1'b1;
      pdStat      <= 1'b0;
      accessReady <= 1'b1;
    end else begin
      state <= nxt;
      if (strb.enter) begin
        cke         <= 1'b0;
        pdStat      <= 1'b1;
        accessReady <= 1'b0;
      end
      if (strb.leave) begin
        cke    <= 1'b1;
        pdStat <= 1'b0;
      end
      if (strb.inExit && flags.exitDone) accessReady <= 1'b1;
    end
  end
endmodule

// File: rtl/cke_pd_dp.sv
module cke_pd_dp
  import cke_pd_pkg::*;
#(
  parameter int TW = 8,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  pdStrobe_t     strb,
  input  logic          slowExit,
  input  logic [TW-1:0] tCke,
  input  logic [TW-1:0] tXp,
  input  logic [TW-1:0] tXard,
  input  logic [TW-1:0] tXards,
  input  logic [RW-1:0] resLimit,
  output pdFlag_t       flags,
  output logic          overrun
);
  localparam logic [RW-1:0] LOW_MAX  = {RW{1'b1}};
  localparam logic [TW-1:0] EXIT_MAX = {TW{1'b1}};

  logic [RW-1:0] lowCnt;
  logic [TW-1:0] exitCnt;
  logic [TW-1:0] activeWait;
  logic [TW-1:0] waitMax;
  logic [RW:0]   lowElapsed;
  logic [TW:0]   exitElapsed;

  always_comb begin
    activeWait  = slowExit ? tXards : tXard;
    waitMax     = (tXp > activeWait) ? tXp : activeWait;
    lowElapsed  = {1'b0, lowCnt} + 1'b1;
    exitElapsed = {1'b0, exitCnt} + 1'b1;
    flags.lowDone  = lowElapsed >= (RW+1)'(tCke);
    flags.exitDone = exitElapsed >= {1'b0, waitMax};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowCnt  <= '0;
      exitCnt <= '0;
      overrun <= 1'b0;
    end else begin
      if (strb.enter) lowCnt <= '0;
      else if (strb.inPd && lowCnt != LOW_MAX) lowCnt <= lowCnt + 1'b1;

      if (strb.leave) exitCnt <= '0;
      else if (strb.inExit && exitCnt != EXIT_MAX) exitCnt <= exitCnt + 1'b1;

      if (strb.inPd && lowElapsed > {1'b0, resLimit}) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/cke_pd_seq.sv
module cke_pd_seq
  import cke_pd_pkg::*;
#(
  parameter int TW = 8,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pdReq,
  input  logic          accBusy,
  input  logic          queuePend,
  input  logic          slowExit,
  input  logic [TW-1:0] tCke,
  input  logic [TW-1:0] tXp,
  input  logic [TW-1:0] tXard,
  input  logic [TW-1:0] tXards,
  input  logic [RW-1:0] resLimit,
  output logic          cke,
  output logic          pdStat,
  output logic          accessReady,
  output logic          overrun
);
  pdStrobe_t strb;
  pdFlag_t   flags;

  cke_pd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pdReq(pdReq), .accBusy(accBusy),
    .queuePend(queuePend), .flags(flags), .strb(strb),
    .cke(cke), .pdStat(pdStat), .accessReady(accessReady)
  );

  cke_pd_dp #(.TW(TW), .RW(RW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .slowExit(slowExit),
    .tCke(tCke), .tXp(tXp), .tXard(tXard), .tXards(tXards),
    .resLimit(resLimit), .flags(flags), .overrun(overrun)
  );
endmodule

// File: rtl/cke_pd_chk.sv
module cke_pd_chk (
  input logic clk,
  input logic rstN,
  input logic pdReq,
  input logic accBusy,
  input logic queuePend,
  input logic cke,
  input logic pdStat,
  input logic accessReady,
  input logic overrun
);
  a_r2_idle_entry: assert property (@(posedge clk) disable iff (!rstN)
    (accessReady && pdReq && !accBusy && !queuePend) |=> (!cke && pdStat));

  a_r3_defer_busy: assert property (@(posedge clk) disable iff (!rstN)
    (cke && accessReady && (accBusy || queuePend)) |=> cke);

  a_r4_no_request: assert property (@(posedge clk) disable iff (!rstN)
    (cke && accessReady && !pdReq) |=> cke);

  a_r5_hold_low: assert property (@(posedge clk) disable iff (!rstN)
    (!cke && pdReq) |=> !cke);

  a_r6_stat_mirror: assert property (@(posedge clk) disable iff (!rstN)
    pdStat == !cke);

  a_r10_ready_gated: assert property (@(posedge clk) disable iff (!rstN)
    (!cke || $rose(cke)) |-> !accessReady);

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);
endmodule

bind cke_pd_seq cke_pd_chk u_chk (
  .clk(clk), .rstN(rstN), .pdReq(pdReq), .accBusy(accBusy),
  .queuePend(queuePend), .cke(cke), .pdStat(pdStat),
  .accessReady(accessReady), .overrun(overrun)
);

// File: tb/sim_cke_pd_seq.sv
module sim_cke_pd_seq;
  localparam int TW = 8;
  localparam int RW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pdReq = 1'b0, accBusy = 1'b0, queuePend = 1'b0, slowExit = 1'b0;
  logic [TW-1:0] tCke = 8'd3, tXp = 8'd2, tXard = 8'd4, tXards = 8'd6;
  logic [RW-1:0] resLimit = 16'd1000;
  logic cke, pdStat, accessReady, overrun;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cke_pd_seq #(.TW(TW), .RW(RW)) u0 (
    .clk(clk), .rstN(rstN), .pdReq(pdReq), .accBusy(accBusy),
    .queuePend(queuePend), .slowExit(slowExit), .tCke(tCke), .tXp(tXp),
    .tXard(tXard), .tXards(tXards), .resLimit(resLimit),
    .cke(cke), .pdStat(pdStat), .accessReady(accessReady), .overrun(overrun)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tReset();
    check(cke, 1'b1, "R1 cke");
    check(pdStat, 1'b0, "R1 pdStat");
    check(accessReady, 1'b1, "R1 accessReady");
    check(overrun, 1'b0, "R1 overrun");
  endtask

  task automatic tNoRequest();
    pdReq = 0;
    for (int i = 0; i < 5; i++) begin
      accBusy = i[0]; queuePend = i[1];
      step(1);
      check(cke, 1'b1, "R4 cke");
      check(accessReady, 1'b1, "R4 accessReady");
    end
    accBusy = 0; queuePend = 0;
  endtask

  task automatic tIdleEntryLateExit();
    tCke = 3; slowExit = 0; tXp = 2; tXard = 4; tXards = 6;
    pdReq = 1;
    step(1);
    check(cke, 1'b0, "R2 cke");
    check(pdStat, 1'b1, "R2 pdStat");
    check(accessReady, 1'b0, "R2 accessReady");
    for (int i = 0; i < 5; i++) begin
      accBusy = ~i[0]; queuePend = i[0];
      step(1);
      check(cke, 1'b0, "R5 cke");
      check(accessReady, 1'b0, "R5 accessReady");
    end
    accBusy = 0; queuePend = 0;
    pdReq = 0;
    step(1);
    check(cke, 1'b1, "R8 cke");
    check(pdStat, 1'b0, "R6 pdStat");
    check(accessReady, 1'b0, "R10 accessReady");
    step(3);
    check(accessReady, 1'b0, "R9 early W=4");
    step(1);
    check(accessReady, 1'b1, "R9 due W=4");
    check(overrun, 1'b0, "R11 no overrun");
  endtask

  task automatic tDeferredEarlyExit();
    tCke = 5; slowExit = 1;
    accBusy = 1; queuePend = 1; pdReq = 1;
    step(3);
    check(cke, 1'b1, "R3 busy");
    accBusy = 0;
    step(2);
    check(cke, 1'b1, "R3 queued");
    queuePend = 0;
    step(1);
    check(cke, 1'b0, "R3 entered");
    pdReq = 0;
    step(4);
    check(cke, 1'b0, "R7 still low");
    step(1);
    check(cke, 1'b1, "R7 rise at tCke");
    check(pdStat, 1'b0, "R6 pdStat");
    step(5);
    check(accessReady, 1'b0, "R9 early W=6");
    step(1);
    check(accessReady, 1'b1, "R9 due W=6");
  endtask

  task automatic tOverrunZeroWait();
    tCke = 1; resLimit = 10; tXp = 0; tXard = 0; slowExit = 0;
    pdReq = 1;
    step(1);
    check(cke, 1'b0, "R2 entry");
    step(10);
    check(overrun, 1'b0, "R11 before limit");
    step(1);
    check(overrun, 1'b1, "R11 after limit");
    pdReq = 0;
    step(1);
    check(cke, 1'b1, "R8 rise");
    check(accessReady, 1'b0, "R10 rise cycle");
    step(1);
    check(accessReady, 1'b1, "R9 W=0");
    step(3);
    check(overrun, 1'b1, "R11 sticky");
  endtask

  initial begin
    step(3);
    rstN = 1;
    step(1);
    tReset();
    tNoRequest();
    tIdleEntryLateExit();
    step(2);
    tDeferredEarlyExit();
    step(2);
    tOverrunZeroWait();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule